// File: doc/BRIEF.md
# Tagged 512-Bit Chunk Assembler

The assembler sits between a pair of 10-bit video streams and a wide memory write port. Each cycle it can take one word from each stream and packs the pair into a 500-bit payload register, filling from the most significant end downward. It places a 12-bit content tag above the payload to form a 512-bit chunk. Bits below the last filled position are zero. A chunk is closed in one of two ways: the payload register fills, or a pair carries the frame-end marker.

Short items arrive already classified on a separate item port: metadata (40 bits), audio blocks (80 bits) and timecodes (80 bits). Each item gets a chunk of its own with the matching tag and zero fill. Any partly filled video payload is kept untouched while the item chunk goes out.

When a chunk is complete, `chunk_rdy` pulses high for one cycle. `chunk_out` then holds the chunk until the consumer raises `chunk_ack`. Until that acknowledge arrives, both input ready signals stay low. The sequencer has three states:
- `ST_FILL`: accepting input.
- `ST_HOLD_VID`: a video chunk is waiting.
- `ST_HOLD_ITEM`: an item chunk is waiting.

The transitions are:
- `ST_FILL` to `ST_HOLD_ITEM` on an accepted item.
- `ST_FILL` to `ST_HOLD_VID` on an accepted pair that fills the payload or carries frame end.
- Either hold state back to `ST_FILL` on `chunk_ack`.

Top module: `tagged_chunk_asm`

## Requirements
- R1: After reset no chunk is pending: `chunk_rdy` is 0, `item_rdy` is 1, and `vid_rdy` is 1 while `item_valid` is 0.
- R2: Every chunk has its tag in bits [511:500] and its payload in bits [499:0]. The tag is one of 0x001 (video), 0x009 (last video chunk of a frame), 0x002 (metadata), 0x003 (audio) or 0x004 (timecode).
- R3: The k-th accepted pair of a video chunk (k from 0) occupies bits [499-20k : 480-20k], with `vid_a` in the upper 10 bits. The 25th pair closes the chunk with tag 0x001.
- R4: A pair accepted with `vid_last` high closes the chunk at once with tag 0x009, whether it is the 25th pair or an earlier one. All payload bits below it are 0.
- R5: `item_kind` 00 (metadata) gives tag 0x002 with `item_data[39:0]` in bits [499:460]. All other payload bits are 0, whatever `item_data[79:40]` holds.
- R6: `item_kind` 01 (audio) gives tag 0x003 with `item_data[79:0]` in bits [499:420] and zeros below.
- R7: `item_kind` 10 or 11 (timecode) gives tag 0x004 with `item_data[79:0]` in bits [499:420] and zeros below.
- R8: `chunk_rdy` is high for exactly one cycle: the cycle after the clock edge that accepted the closing pair or the item.
- R9: From the `chunk_rdy` cycle until the edge that samples `chunk_ack` high, `vid_rdy` and `item_rdy` are 0 and `chunk_out` is stable. On the cycle after that edge, `item_rdy` is 1 again.
- R10: An item has priority over video: while `item_valid` is high, `vid_rdy` is 0. A partly filled video payload survives an item chunk, and packing continues at the next free position.
- R11: After a video chunk is acknowledged, the next video chunk starts from an all-zero payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_valid | input | 1 | A word pair is offered |
| vid_a | input | 10 | First stream word (upper half of the pair) |
| vid_b | input | 10 | Second stream word (lower half of the pair) |
| vid_last | input | 1 | Offered pair is the last of a frame |
| vid_rdy | output | 1 | Pair accepted at the next edge if `vid_valid` |
| item_valid | input | 1 | A short item is offered |
| item_kind | input | 2 | 00 metadata, 01 audio, 1x timecode |
| item_data | input | 80 | Item bits; metadata uses [39:0] |
| item_rdy | output | 1 | Item accepted at the next edge if `item_valid` |
| chunk_out | output | 512 | Tag and payload of the pending chunk |
| chunk_rdy | output | 1 | One-cycle pulse: a new chunk is on `chunk_out` |
| chunk_ack | input | 1 | Consumer has taken the pending chunk |

## Verification
The assertions assume that `chunk_ack` is raised only while a chunk is pending. They also assume that `vid_last` is meaningful only together with `vid_valid`. The bench meets both. Its consumer process raises `chunk_ack` only after it has seen `chunk_rdy`, and it waits zero, one or two cycles before doing so. The driver tasks set `vid_last` only on the pair they are offering, and they hold an offer steady until the matching ready is seen before a clock edge.

// File: rtl/tca_pkg.sv
package tca_pkg;

    localparam int TAG_W = 12;

    localparam logic [TAG_W-1:0] TAG_VIDEO = 12'h001;
    localparam logic [TAG_W-1:0] TAG_META  = 12'h002;
    localparam logic [TAG_W-1:0] TAG_AUDIO = 12'h003;
    localparam logic [TAG_W-1:0] TAG_TCODE = 12'h004;
    localparam logic [TAG_W-1:0] TAG_LAST  = 12'h008;

    typedef enum logic [1:0] {
        ST_FILL      = 2'd0,
        ST_HOLD_VID  = 2'd1,
        ST_HOLD_ITEM = 2'd2
    } tca_state_e;

    function automatic logic [TAG_W-1:0] item_tag(input logic [1:0] kind);
        logic [TAG_W-1:0] t;
        if (kind[1])          t = TAG_TCODE;
        else if (kind[0])     t = TAG_AUDIO;
        else                  t = TAG_META;
        return t;
    endfunction

endpackage

// File: rtl/tca_vid_pack.sv
module tca_vid_pack #(
    parameter int WORD_W    = 10,
    parameter int PAYLOAD_W = 500
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   wr,
    input  logic [2*WORD_W-1:0]    pair_in,
    input  logic                   last_in,
    output logic                   at_close,
    output logic                   last_q,
    output logic [PAYLOAD_W-1:0]   payload
);

    localparam int PAIR_W = 2 * WORD_W;
    localparam int SLOTS  = PAYLOAD_W / PAIR_W;
    localparam int REM_W  = PAYLOAD_W - SLOTS * PAIR_W;
    localparam int CNT_W  = $clog2(SLOTS + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= 1'b0;
        end else if (clr) begin
            cnt_q  <= '0;
            last_q <= 1'b0;
        end else if (wr) begin
            if (cnt_q < CNT_W'(SLOTS)) cnt_q <= cnt_q + 1'b1;
            if (last_in) last_q <= 1'b1;
        end
    end

    assign at_close = last_in || (cnt_q == CNT_W'(SLOTS - 1));

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [PAIR_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                q <= '0;
            else if (clr)                              q <= '0;
            else if (wr && (cnt_q == CNT_W'(s)))       q <= pair_in;
        end
        assign payload[PAYLOAD_W-1-s*PAIR_W -: PAIR_W] = q;
    end

    if (REM_W > 0) begin : g_rem
        assign payload[REM_W-1:0] = '0;
    end

endmodule

// File: rtl/tca_item_slot.sv
module tca_item_slot
    import tca_pkg::*;
#(
    parameter int PAYLOAD_W = 500,
    parameter int ITEM_W    = 80,
    parameter int META_W    = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [1:0]           kind,
    input  logic [ITEM_W-1:0]    data,
    output logic [TAG_W-1:0]     tag,
    output logic [PAYLOAD_W-1:0] payload
);

    logic [ITEM_W-1:0] item_q;
    logic [TAG_W-1:0]  tag_q;
    logic              is_meta;

    assign is_meta = (kind == 2'b00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            item_q <= '0;
            tag_q  <= TAG_META;
        end else if (load) begin
            tag_q  <= item_tag(kind);
            item_q <= is_meta ? {data[META_W-1:0], {(ITEM_W-META_W){1'b0}}} : data;
        end
    end

    assign tag     = tag_q;
    assign payload = {item_q, {(PAYLOAD_W-ITEM_W){1'b0}}};

endmodule

// File: rtl/tca_ctrl.sv
module tca_ctrl
    import tca_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vid_valid,
    input  logic item_valid,
    input  logic at_close,
    input  logic chunk_ack,
    output logic vid_rdy,
    output logic item_rdy,
    output logic vid_wr,
    output logic item_load,
    output logic vid_clr,
    output logic sel_item,
    output logic chunk_rdy
);

    tca_state_e state_q, state_d;
    logic       rdy_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            rdy_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rdy_q   <= (state_q == ST_FILL) && (state_d != ST_FILL);
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: begin
                if (item_valid)                    state_d = ST_HOLD_ITEM;
                else if (vid_valid && at_close)    state_d = ST_HOLD_VID;
            end
            ST_HOLD_VID: begin
                if (chunk_ack)                     state_d = ST_FILL;
            end
            ST_HOLD_ITEM: begin
                if (chunk_ack)                     state_d = ST_FILL;
            end
            default:                               state_d = ST_FILL;
        endcase
    end

    // outputs
    always_comb begin
        item_rdy  = 1'b0;
        vid_rdy   = 1'b0;
        vid_clr   = 1'b0;
        sel_item  = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                item_rdy = 1'b1;
                vid_rdy  = !item_valid;
            end
            ST_HOLD_VID: begin
                vid_clr  = chunk_ack;
            end
            ST_HOLD_ITEM: begin
                sel_item = 1'b1;
            end
            default: begin
                item_rdy = 1'b0;
            end
        endcase
        vid_wr    = vid_rdy && vid_valid;
        item_load = item_rdy && item_valid;
    end

    assign chunk_rdy = rdy_q;

endmodule

// File: rtl/tagged_chunk_asm.sv
module tagged_chunk_asm
    import tca_pkg::*;
#(
    parameter int WORD_W    = 10,
    parameter int PAYLOAD_W = 500,
    parameter int ITEM_W    = 80,
    parameter int META_W    = 40,
    localparam int CHUNK_W  = TAG_W + PAYLOAD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vid_valid,
    input  logic [WORD_W-1:0]   vid_a,
    input  logic [WORD_W-1:0]   vid_b,
    input  logic                vid_last,
    output logic                vid_rdy,
    input  logic                item_valid,
    input  logic [1:0]          item_kind,
    input  logic [ITEM_W-1:0]   item_data,
    output logic                item_rdy,
    output logic [CHUNK_W-1:0]  chunk_out,
    output logic                chunk_rdy,
    input  logic                chunk_ack
);

    logic                 vid_wr, item_load, vid_clr, sel_item;
    logic                 at_close, last_q;
    logic [PAYLOAD_W-1:0] vid_payload, item_payload;
    logic [TAG_W-1:0]     item_tag_w, vid_tag_w;

    tca_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .vid_valid  (vid_valid),
        .item_valid (item_valid),
        .at_close   (at_close),
        .chunk_ack  (chunk_ack),
        .vid_rdy    (vid_rdy),
        .item_rdy   (item_rdy),
        .vid_wr     (vid_wr),
        .item_load  (item_load),
        .vid_clr    (vid_clr),
        .sel_item   (sel_item),
        .chunk_rdy  (chunk_rdy)
    );

    tca_vid_pack #(.WORD_W(WORD_W), .PAYLOAD_W(PAYLOAD_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (vid_clr),
        .wr       (vid_wr),
        .pair_in  ({vid_a, vid_b}),
        .last_in  (vid_last),
        .at_close (at_close),
        .last_q   (last_q),
        .payload  (vid_payload)
    );

    tca_item_slot #(.PAYLOAD_W(PAYLOAD_W), .ITEM_W(ITEM_W), .META_W(META_W)) u_item (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (item_load),
        .kind    (item_kind),
        .data    (item_data),
        .tag     (item_tag_w),
        .payload (item_payload)
    );

    assign vid_tag_w = last_q ? (TAG_VIDEO | TAG_LAST) : TAG_VIDEO;
    assign chunk_out = sel_item ? {item_tag_w, item_payload} : {vid_tag_w, vid_payload};

endmodule

// File: rtl/tca_chk.sv
module tca_chk #(
    parameter int PAYLOAD_W = 500,
    parameter int META_W    = 40,
    parameter int CHUNK_W   = 512
) (
    input logic               clk,
    input logic               rst_n,
    input logic               item_valid,
    input logic               chunk_ack,
    input logic               vid_rdy,
    input logic               item_rdy,
    input logic               chunk_rdy,
    input logic [CHUNK_W-1:0] chunk_out
);

    logic [CHUNK_W-PAYLOAD_W-1:0] tag;
    assign tag = chunk_out[CHUNK_W-1:PAYLOAD_W];

    AST_RDY_PULSE:    assert property (@(posedge clk) disable iff (!rst_n)
        chunk_rdy |=> !chunk_rdy);                                           // R8
    AST_RDY_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(item_rdy) |-> chunk_rdy);                                      // R8
    AST_RDY_IN_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
        chunk_rdy |-> !item_rdy);                                            // R9
    AST_STALL_VIDEO:  assert property (@(posedge clk) disable iff (!rst_n)
        !item_rdy |-> !vid_rdy);                                             // R9
    AST_HOLD_STABLE:  assert property (@(posedge clk) disable iff (!rst_n)
        (!item_rdy && !chunk_ack) |=> ($stable(chunk_out) && !item_rdy));   // R9
    AST_ACK_RELEASE:  assert property (@(posedge clk) disable iff (!rst_n)
        (!item_rdy && chunk_ack) |=> item_rdy);                              // R9
    AST_ITEM_FIRST:   assert property (@(posedge clk) disable iff (!rst_n)
        item_valid |-> !vid_rdy);                                            // R10
    AST_TAG_LEGAL:    assert property (@(posedge clk) disable iff (!rst_n)
        chunk_rdy |-> (tag == 12'h001 || tag == 12'h009 || tag == 12'h002 ||
                       tag == 12'h003 || tag == 12'h004));                   // R2
    AST_META_PAD:     assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_rdy && tag == 12'h002) |-> (chunk_out[PAYLOAD_W-META_W-1:0] == '0)); // R5

endmodule

bind tagged_chunk_asm tca_chk #(
    .PAYLOAD_W (PAYLOAD_W),
    .META_W    (META_W),
    .CHUNK_W   (CHUNK_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .item_valid (item_valid),
    .chunk_ack  (chunk_ack),
    .vid_rdy    (vid_rdy),
    .item_rdy   (item_rdy),
    .chunk_rdy  (chunk_rdy),
    .chunk_out  (chunk_out)
);

// File: tb/tagged_chunk_asm_bench.sv
module tagged_chunk_asm_bench;

    localparam int PW = 500;
    localparam int CW = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vid_valid = 1'b0;
    logic [9:0]    vid_a = '0;
    logic [9:0]    vid_b = '0;
    logic          vid_last = 1'b0;
    logic          vid_rdy;
    logic          item_valid = 1'b0;
    logic [1:0]    item_kind = '0;
    logic [79:0]   item_data = '0;
    logic          item_rdy;
    logic [CW-1:0] chunk_out;
    logic          chunk_rdy;
    logic          chunk_ack = 1'b0;

    tagged_chunk_asm u_tagged_chunk_asm (
        .clk(clk), .rst_n(rst_n),
        .vid_valid(vid_valid), .vid_a(vid_a), .vid_b(vid_b), .vid_last(vid_last), .vid_rdy(vid_rdy),
        .item_valid(item_valid), .item_kind(item_kind), .item_data(item_data), .item_rdy(item_rdy),
        .chunk_out(chunk_out), .chunk_rdy(chunk_rdy), .chunk_ack(chunk_ack)
    );

    initial forever #10 clk = ~clk;

    int  checks = 0;
    int  errors = 0;
    int  nchunks = 0;
    bit  just_fired = 1'b0;
    bit  done = 1'b0;
    logic [CW-1:0] exp_q[$];
    logic [PW-1:0] ebuf = '0;
    int  en = 0;

    task automatic chk(input bit ok, input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // expected video chunk model (R3, R4, R11)
    task automatic model_vid(input logic [9:0] a, input logic [9:0] b, input bit last);
        ebuf[PW-1-20*en -: 20] = {a, b};
        en++;
        if (last || en == 25) begin
            exp_q.push_back({(last ? 12'h009 : 12'h001), ebuf});
            ebuf = '0;
            en = 0;
        end
    endtask

    // expected item chunk model (R5, R6, R7)
    task automatic model_item(input logic [1:0] k, input logic [79:0] d);
        if (k == 2'b00)      exp_q.push_back({12'h002, d[39:0], 460'b0});
        else if (k == 2'b01) exp_q.push_back({12'h003, d, 420'b0});
        else                 exp_q.push_back({12'h004, d, 420'b0});
    endtask

    task automatic push_pair(input logic [9:0] a, input logic [9:0] b, input bit last);
        vid_valid = 1'b1; vid_a = a; vid_b = b; vid_last = last;
        #1;
        while (!vid_rdy) begin @(negedge clk); #1; end
        @(posedge clk);
        just_fired = 1'b1;
        model_vid(a, b, last);
        @(negedge clk);
        vid_valid = 1'b0; vid_last = 1'b0;
    endtask

    task automatic push_item(input logic [1:0] k, input logic [79:0] d);
        item_valid = 1'b1; item_kind = k; item_data = d;
        #1;
        while (!item_rdy) begin @(negedge clk); #1; end
        @(posedge clk);
        just_fired = 1'b1;
        model_item(k, d);
        @(negedge clk);
        item_valid = 1'b0;
    endtask

    task automatic both_valid(input logic [9:0] a, input logic [9:0] b, input logic [1:0] k, input logic [79:0] d);
        vid_valid = 1'b1; vid_a = a; vid_b = b; vid_last = 1'b0;
        item_valid = 1'b1; item_kind = k; item_data = d;
        #1;
        while (!item_rdy) begin @(negedge clk); #1; end
        chk(vid_rdy == 1'b0, "R10 vid_rdy low while item offered", vid_rdy, 0);
        @(posedge clk);
        just_fired = 1'b1;
        model_item(k, d);
        @(negedge clk);
        item_valid = 1'b0;
        #1;
        while (!vid_rdy) begin @(negedge clk); #1; end
        @(posedge clk);
        just_fired = 1'b1;
        model_vid(a, b, 1'b0);
        @(negedge clk);
        vid_valid = 1'b0;
    endtask

    // scoreboard monitor and consumer
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && chunk_rdy) begin
                logic [CW-1:0] snap;
                logic [CW-1:0] exp;
                int gap;
                chk(just_fired, "R8 pulse follows accepting edge", just_fired, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected chunk", chunk_out, 0);
                end else begin
                    exp = exp_q.pop_front();
                    chk(chunk_out === exp, "R2/R3/R4/R5/R6/R7/R10/R11 chunk content", chunk_out, exp);
                end
                just_fired = 1'b0;
                nchunks++;
                gap = nchunks % 3;
                snap = chunk_out;
                for (int i = 0; i < gap; i++) begin
                    @(negedge clk);
                    if (i == 0) chk(chunk_rdy == 1'b0, "R8 pulse one cycle", chunk_rdy, 0);
                    chk(!vid_rdy && !item_rdy, "R9 inputs held off", {vid_rdy, item_rdy}, 0);
                    chk(chunk_out === snap, "R9 chunk stable", chunk_out, snap);
                end
                chunk_ack = 1'b1;
                @(negedge clk);
                chunk_ack = 1'b0;
                if (gap == 0) chk(chunk_rdy == 1'b0, "R8 pulse one cycle", chunk_rdy, 0);
                chk(item_rdy == 1'b1, "R9 released after ack", item_rdy, 1);
            end else begin
                just_fired = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(chunk_rdy == 1'b0 && item_rdy == 1'b1 && vid_rdy == 1'b1, "R1 idle in reset",
            {chunk_rdy, item_rdy, vid_rdy}, 3'b011);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(chunk_rdy == 1'b0 && item_rdy == 1'b1 && vid_rdy == 1'b1, "R1 idle after reset",
            {chunk_rdy, item_rdy, vid_rdy}, 3'b011);
        @(negedge clk);

        // R3: full chunk of 25 pairs
        for (int k = 0; k < 25; k++) push_pair(10'(k), 10'(10'h3FF - k), 1'b0);
        // R4: short final chunk
        for (int k = 0; k < 7; k++) push_pair(10'(10'h100 + k), 10'h055, k == 6);
        // R4: frame end on the 25th pair
        for (int k = 0; k < 25; k++) push_pair(10'(k * 3), 10'(k * 5 + 1), k == 24);
        // R5: metadata, upper item bits ignored
        push_item(2'b00, 80'hFFFF_FFFF_FF12_3456_789A);
        // R6: audio
        push_item(2'b01, 80'hA5A5_0123_4567_89AB_CDEF);
        // R7: timecode, both encodings
        push_item(2'b10, 80'h1122_3344_5566_7788_99AA);
        push_item(2'b11, 80'hDEAD_BEEF_0000_1111_2222);
        // R10: item between video pairs keeps the partial buffer
        for (int k = 0; k < 5; k++) push_pair(10'(10'h200 + k), 10'(10'h040 + k), 1'b0);
        both_valid(10'h2AA, 10'h155, 2'b00, 80'h0000_0000_00C0_FFEE_1234);
        for (int k = 6; k < 25; k++) push_pair(10'(10'h300 + k), 10'(k), 1'b0);
        // R11: new chunk starts from zero
        for (int k = 0; k < 3; k++) push_pair(10'h3FF, 10'h3FF, k == 2);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all expected chunks produced", exp_q.size(), 0);
        done = 1'b1;
        summary();
    end

endmodule